// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous static RAM with a registered address and registered control. Its read data flows straight from the array, with no output register. Each rising clock edge decodes the chip selects, the two burst-start strobes, the advance input and the write controls into one of four cycle types: deselect, burst start, burst continue or burst suspend. Each cycle is a read or a write. Writes take effect at the same edge that registers the address. Read data for that address appears at the output before the following edge.

The block keeps a two-bit burst offset inside an aligned group of four words. Depending on the order-select input, the offset steps through the group in either counting order or XOR order. A controller issues one address and then advances through the group with the advance input, without repeating the chip selects. The data output has a drive qualifier in place of a tri-state pin. A sleep input freezes the block. The storage depth is a parameter.

Top module: `fts_sram`

## Requirements
- R1: When `gwr_n` is 0 on a write-capable cycle, all four byte lanes of the addressed word are written, whatever `bwe_n` and `ben_n` hold.
- R2: When `gwr_n` is 1 and `bwe_n` is 0, lane i is written only if `ben_n[i]` is 0. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R3: When `gwr_n` is 1 and either `bwe_n` is 1 or `ben_n` is 4'hF, the cycle is a read and the array is left unchanged.
- R4: A processor-strobe start (`proc_strb_n`=0 with `ce1_n`=0 and all selects active) is a read, even when the write controls ask for a write.
- R5: A start (`ctrl_strb_n`=0, or `proc_strb_n`=0 with `ce1_n`=0) with any select inactive (`ce1_n`=1, `ce2_hi`=0 or `ce3_n`=1) deselects the block. Following continue and suspend cycles leave it deselected.
- R6: `drive_o` is 1 only on a selected read cycle with `oe_n`=0. It is 0 on write cycles. `rdata_o` is zero whenever `drive_o` is 0.
- R7: With `ctrl_strb_n`=1 and `ce1_n`=1, the cycle is a continue or a suspend of the current burst. The selects and `proc_strb_n` are ignored.
- R8: In a burst that starts at low address bits b, beat k uses low bits b XOR k when `order_ilv`=1 and (b+k) mod 4 when `order_ilv`=0. The upper address bits stay fixed, and the offset wraps within the group of four.
- R9: A continue cycle with `adv_n`=1 keeps the current address.
- R10: The read data of the address registered at an edge is on `rdata_o` before the next edge. A write goes to the address registered at that same edge.
- R11: While `sleep_i` is 1, cycles are ignored, `drive_o` is 0 and the array is retained. When `sleep_i` returns to 0, the burst state in force before sleep resumes.
- R12: During and right after reset the block is deselected and `drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address, low two bits are the burst base |
| proc_strb_n | input | 1 | Processor burst-start strobe, active low, always read |
| ctrl_strb_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary select, active low |
| ce2_hi | input | 1 | Second select, active high |
| ce3_n | input | 1 | Third select, active low |
| gwr_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| ben_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| sleep_i | input | 1 | Sleep request, active high |
| order_ilv | input | 1 | Burst order: 1 XOR order, 0 counting order |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when not driven |
| drive_o | output | 1 | Output valid / bus drive |

## Verification
The checker watches, on every cycle, that the output is never driven during sleep, with output enable high, after a write start, or after a deselecting start. It also checks that a processor-strobe start always gives a driven read. Data correctness is shown only by the bench scenarios. These cover the byte-lane merge for all sixteen lane masks, the beat order for every base offset in both burst orders, suspend holding an address, continues with the selects idle, and contents surviving a write attempted during sleep.

// File: rtl/fts_pkg.sv
package fts_pkg;

   // Selected/write state held between edges
   typedef struct packed {
      logic sel;
      logic wr;
   } cyc_t;

   // Low address bits for beat k of a burst based at b
   function automatic logic [1:0] beat_lo(input logic [1:0] b,
                                          input logic [1:0] k,
                                          input logic       ilv);
      return ilv ? (b ^ k) : (b + k);
   endfunction

endpackage

// File: rtl/fts_wr_decode.sv
module fts_wr_decode #(
   parameter int NB = 4
) (
   input  logic          gwr_n,
   input  logic          bwe_n,
   input  logic [NB-1:0] ben_n,
   output logic [NB-1:0] lane_we,
   output logic          any_wr
);
   always_comb begin
      if (!gwr_n)      lane_we = '1;
      else if (!bwe_n) lane_we = ~ben_n;
      else             lane_we = '0;
   end
   assign any_wr = |lane_we;
endmodule

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       load,
   input  logic [1:0] load_lo,
   input  logic       ilv_i,
   input  logic       adv,
   output logic [1:0] cur_lo,
   output logic [1:0] nxt_lo
);
   import fts_pkg::*;

   logic [1:0] base_q;
   logic [1:0] cnt_q;
   logic       ilv_q;

   assign cur_lo = beat_lo(base_q, cnt_q, ilv_q);

   always_comb begin
      if (load)     nxt_lo = load_lo;
      else if (adv) nxt_lo = beat_lo(base_q, cnt_q + 2'd1, ilv_q);
      else          nxt_lo = cur_lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         ilv_q  <= 1'b0;
      end else if (en) begin
         if (load) begin
            base_q <= load_lo;
            cnt_q  <= '0;
            ilv_q  <= ilv_i;
         end else if (adv) begin
            cnt_q <= cnt_q + 2'd1;
         end
      end
   end
endmodule

// File: rtl/fts_array.sv
module fts_array #(
   parameter int AW = 6,
   parameter int DW = 32,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [NB-1:0] lane_we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int LW    = DW / NB;
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_we[g]) mem[waddr] <= wdata[g*LW +: LW];
      end

      assign rdata[g*LW +: LW] = mem[raddr];
   end
endmodule

// File: rtl/fts_sram.sv
module fts_sram #(
   parameter int AW = 6,
   parameter int DW = 32,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          proc_strb_n,
   input  logic          ctrl_strb_n,
   input  logic          adv_n,
   input  logic          ce1_n,
   input  logic          ce2_hi,
   input  logic          ce3_n,
   input  logic          gwr_n,
   input  logic          bwe_n,
   input  logic [NB-1:0] ben_n,
   input  logic          oe_n,
   input  logic          sleep_i,
   input  logic          order_ilv,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          drive_o
);
   import fts_pkg::*;

   localparam int HW = AW - 2;

   if (AW < 3) begin : g_bad_aw
      $error("fts_sram: AW must be at least 3");
   end
   if (DW % NB != 0) begin : g_bad_dw
      $error("fts_sram: DW must divide evenly into NB lanes");
   end

   cyc_t          cyc_q, cyc_d;
   logic [HW-1:0] hi_q, hi_d;
   logic [1:0]    cur_lo, nxt_lo;
   logic [NB-1:0] lane_we;
   logic          any_wr;
   logic [DW-1:0] arr_rd;

   logic awake, ce_ok, proc_go, start, load, adv_go;

   assign awake   = !sleep_i;
   assign ce_ok   = !ce1_n && ce2_hi && !ce3_n;
   assign proc_go = !ce1_n && !proc_strb_n;
   assign start   = proc_go || !ctrl_strb_n;
   assign load    = start && ce_ok;
   assign adv_go  = !start && cyc_q.sel && !adv_n;

   fts_wr_decode #(.NB(NB)) u_wdec (
      .gwr_n   (gwr_n),
      .bwe_n   (bwe_n),
      .ben_n   (ben_n),
      .lane_we (lane_we),
      .any_wr  (any_wr)
   );

   always_comb begin
      if (start) begin
         cyc_d.sel = ce_ok;
         cyc_d.wr  = ce_ok && !proc_go && any_wr;
      end else begin
         cyc_d.sel = cyc_q.sel;
         cyc_d.wr  = cyc_q.sel && any_wr;
      end
      hi_d = load ? addr_i[AW-1:2] : hi_q;
   end

   fts_burst_ctr u_bctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (awake),
      .load    (load),
      .load_lo (addr_i[1:0]),
      .ilv_i   (order_ilv),
      .adv     (adv_go),
      .cur_lo  (cur_lo),
      .nxt_lo  (nxt_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         hi_q  <= '0;
      end else if (awake) begin
         cyc_q <= cyc_d;
         hi_q  <= hi_d;
      end
   end

   fts_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
      .clk     (clk),
      .we      (awake && cyc_d.sel && cyc_d.wr),
      .lane_we (lane_we),
      .waddr   ({hi_d, nxt_lo}),
      .wdata   (wdata_i),
      .raddr   ({hi_q, cur_lo}),
      .rdata   (arr_rd)
   );

   assign drive_o = awake && cyc_q.sel && !cyc_q.wr && !oe_n;
   assign rdata_o = drive_o ? arr_rd : '0;
endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic proc_strb_n,
   input logic ctrl_strb_n,
   input logic ce1_n,
   input logic ce2_hi,
   input logic ce3_n,
   input logic gwr_n,
   input logic oe_n,
   input logic sleep_i,
   input logic drive_o
);
   logic sel_ok, go;
   assign sel_ok = !ce1_n && ce2_hi && !ce3_n;
   assign go     = (!ce1_n && !proc_strb_n) || !ctrl_strb_n;

   p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> !drive_o);

   p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_o);

   p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && sel_ok && !proc_strb_n) |=> (drive_o || oe_n || sleep_i));

   p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && sel_ok && proc_strb_n && !ctrl_strb_n && !gwr_n) |=> !drive_o);

   p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && go && !sel_ok) |=> !drive_o);

   always @(negedge clk) begin
      if (!rst_n) p_reset_quiet_r12: assert (!drive_o);
   end
endmodule

bind fts_sram fts_sram_chk u_chk (.*);

// File: tb/fts_sram_tb.sv
module fts_sram_tb;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_i;
   logic          proc_strb_n, ctrl_strb_n, adv_n, ce1_n, ce2_hi, ce3_n;
   logic          gwr_n, bwe_n, oe_n, sleep_i, order_ilv;
   logic [3:0]    ben_n;
   logic [31:0]   wdata_i, rdata_o;
   logic          drive_o;

   logic [31:0] ref_m [1 << AW];
   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   fts_sram #(.AW(AW)) u_dut (.*);

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1; ce1_n = 1; ce2_hi = 1; ce3_n = 0;
      gwr_n = 1; bwe_n = 1; ben_n = 4'hF; oe_n = 1; sleep_i = 0;
   endtask

   task automatic wr_word(input int a, input logic [31:0] d);
      idle(); ctrl_strb_n = 0; ce1_n = 0; gwr_n = 0; oe_n = 0;
      addr_i = AW'(a); wdata_i = d;
      tick();
      ref_m[a] = d;
      chk("R6 write not driven", {31'd0, drive_o}, 32'd0);
      idle();
   endtask

   task automatic rd_word(input string req, input int a);
      idle(); proc_strb_n = 0; ce1_n = 0; oe_n = 0; gwr_n = 0; addr_i = AW'(a);
      tick();
      chk(req, {31'd0, drive_o}, 32'd1);
      chk(req, rdata_o, ref_m[a]);
      idle();
   endtask

   initial begin
      #200000;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(); addr_i = '0; wdata_i = '0; order_ilv = 0; rst_n = 0;
      tick(); tick();
      chk("R12 reset", {31'd0, drive_o}, 32'd0);
      rst_n = 1; oe_n = 0;
      tick();
      chk("R12 after reset", {31'd0, drive_o}, 32'd0);

      // R1 whole-word writes, R4/R10 processor reads with write controls active
      for (int a = 0; a < (1 << AW); a++) wr_word(a, (a * 32'h0103_0507) ^ 32'hA55A_3CC3);
      for (int a = 0; a < (1 << AW); a++) rd_word("R1 R4 R10 read back", a);

      // R2 every lane mask, R3 when mask is empty
      for (int m = 0; m < 16; m++) begin
         logic [31:0] d;
         d = {4{m[3:0], 4'h9}} ^ 32'h1234_5678;
         idle(); ctrl_strb_n = 0; ce1_n = 0; bwe_n = 0; ben_n = ~m[3:0];
         addr_i = AW'(32 + m); wdata_i = d;
         tick();
         for (int l = 0; l < 4; l++) if (m[l]) ref_m[32 + m][l*8 +: 8] = d[l*8 +: 8];
         idle();
         rd_word("R2 R3 lane merge", 32 + m);
      end
      // R3: byte-write qualifier high ignores lane enables
      idle(); ctrl_strb_n = 0; ce1_n = 0; bwe_n = 1; ben_n = 4'h0; oe_n = 0;
      addr_i = AW'(48); wdata_i = 32'hDEAD_BEEF;
      tick();
      chk("R3 read cycle driven", {31'd0, drive_o}, 32'd1);
      chk("R3 read data", rdata_o, ref_m[48]);
      idle();
      rd_word("R3 unchanged", 48);

      // R8 burst order for every base and both orders, R7 selects idle
      for (int o = 0; o < 2; o++) begin
         for (int b = 0; b < 4; b++) begin
            idle(); proc_strb_n = 0; ce1_n = 0; oe_n = 0; order_ilv = o[0];
            addr_i = AW'(20 + b);
            tick();
            chk("R8 beat0", rdata_o, ref_m[20 + b]);
            for (int k = 1; k < 6; k++) begin
               int lo;
               idle(); oe_n = 0; adv_n = 0; proc_strb_n = 0; ce2_hi = 0; ce3_n = 1;
               addr_i = '0;
               tick();
               lo = o ? (b ^ (k % 4)) : ((b + k) % 4);
               chk("R7 R8 continue beat", rdata_o, ref_m[20 + lo]);
            end
            // R9 suspend holds
            idle(); oe_n = 0;
            tick();
            chk("R9 suspend", rdata_o, ref_m[20 + (o ? (b ^ 1) : ((b + 1) % 4))]);
         end
      end
      order_ilv = 0;

      // R10 burst write: start at 14, continue to 15, suspend overwrites 15
      idle(); ctrl_strb_n = 0; ce1_n = 0; gwr_n = 0; addr_i = AW'(14); wdata_i = 32'h1111_0000;
      tick();
      idle(); gwr_n = 0; adv_n = 0; wdata_i = 32'h2222_0000;
      tick();
      idle(); gwr_n = 0; wdata_i = 32'h3333_0000;
      tick();
      ref_m[14] = 32'h1111_0000; ref_m[15] = 32'h3333_0000;
      idle();
      rd_word("R10 burst write 14", 14);
      rd_word("R10 burst write 15", 15);
      rd_word("R10 neighbour 12", 12);

      // R6 output enable high on a read
      idle(); proc_strb_n = 0; ce1_n = 0; oe_n = 1; addr_i = AW'(3);
      tick();
      chk("R6 oe high", {31'd0, drive_o}, 32'd0);
      chk("R6 zero data", rdata_o, 32'd0);
      oe_n = 0; #1;
      chk("R6 oe low", rdata_o, ref_m[3]);

      // R5 deselect by each select
      for (int s = 0; s < 3; s++) begin
         idle(); ctrl_strb_n = 0; ce1_n = (s == 0); ce2_hi = (s != 1); ce3_n = (s == 2);
         oe_n = 0; gwr_n = 0; addr_i = AW'(7); wdata_i = 32'hFFFF_FFFF;
         tick();
         chk("R5 deselected", {31'd0, drive_o}, 32'd0);
         idle(); oe_n = 0; adv_n = 0; gwr_n = 0;
         tick();
         chk("R5 stays deselected", {31'd0, drive_o}, 32'd0);
         idle();
         rd_word("R5 no write", 7);
      end

      // R11 sleep
      idle(); proc_strb_n = 0; ce1_n = 0; oe_n = 0; addr_i = AW'(5);
      tick();
      idle(); sleep_i = 1; ctrl_strb_n = 0; ce1_n = 0; gwr_n = 0; oe_n = 0;
      addr_i = AW'(5); wdata_i = 32'h0BAD_F00D;
      tick();
      chk("R11 sleep no drive", {31'd0, drive_o}, 32'd0);
      idle(); sleep_i = 1; oe_n = 0;
      tick();
      idle(); oe_n = 0;
      #1;
      chk("R11 resume drive", {31'd0, drive_o}, 32'd1);
      chk("R11 retained", rdata_o, ref_m[5]);
      tick();
      chk("R11 suspend after wake", rdata_o, ref_m[5]);

      finish_run();
   end
endmodule